// File: doc/BRIEF.md
# Doorbell Flag Mailbox

A one-way event notification block. A sender writes bit patterns into one of several doorbell channels. Each channel holds a word of independent flags, and each flag stands for one event. The receiver side sees which flags are pending. It can hide flags behind a per-channel mask, and it retires flags with a write-one-to-clear operation. When the receiver retires flags, it can ask for an acknowledge. The acknowledge is then recorded on the sender side as a matching set of acknowledge flags, which the sender clears in turn.

Every interrupt output is a level:
- one transfer interrupt per channel on the receive side;
- one acknowledge interrupt per channel on the send side;
- one combined interrupt covering all of them.

Both sides have a write port and combinational read ports, and each port addresses a channel by index.

Top module: `dbmb_top`

## Requirements
- R1: After reset, all pending flags, mask bits and acknowledge flags are zero, and every interrupt output is low.
- R2: A sender write with `snd_wr_op`=0 sets every flag of channel `snd_ch` whose data bit is 1. Data bits of 0 leave their flags unchanged, and other channels are not affected.
- R3: A receiver write with `rcv_wr_op`=0 clears every pending flag of channel `rcv_ch` whose data bit is 1. Data bits of 0 leave their flags unchanged.
- R4: If the same flag of a channel is set by the sender and cleared by the receiver in the same cycle, the flag ends up set.
- R5: A receiver write with `rcv_wr_op`=1 replaces the mask of channel `rcv_ch`. `xfer_irq[c]` is high exactly while (pending AND NOT mask) of channel c is nonzero.
- R6: A receiver clear with `rcv_ack_req`=1 sets acknowledge flags equal to (data AND pending-before-the-write) on that channel. A clear with `rcv_ack_req`=0 sets no acknowledge flag.
- R7: A sender write with `snd_wr_op`=1 clears the acknowledge flags of channel `snd_ch` whose data bit is 1. A new acknowledge raised in the same cycle on the same flag wins.
- R8: `ack_irq[c]` is high exactly while channel c has any acknowledge flag set.
- R9: `comb_irq` is the OR of all transfer and acknowledge interrupts.
- R10: The read ports return the pending, mask and acknowledge words of the selected channel. A channel index of `NCH` or above reads as zero, and writes to such an index change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snd_wr_en | input | 1 | Sender write strobe |
| snd_wr_op | input | 1 | 0 = set flags, 1 = clear acknowledge flags |
| snd_ch | input | CW | Sender write channel |
| snd_data | input | FW | Sender write data |
| snd_rd_ch | input | CW | Sender read channel |
| snd_rd_pend | output | FW | Pending flags of sender read channel |
| snd_rd_ack | output | FW | Acknowledge flags of sender read channel |
| rcv_wr_en | input | 1 | Receiver write strobe |
| rcv_wr_op | input | 1 | 0 = clear flags, 1 = write mask |
| rcv_ack_req | input | 1 | Request acknowledge with a clear |
| rcv_ch | input | CW | Receiver write channel |
| rcv_data | input | FW | Receiver write data |
| rcv_rd_ch | input | CW | Receiver read channel |
| rcv_rd_pend | output | FW | Pending flags of receiver read channel |
| rcv_rd_mask | output | FW | Mask of receiver read channel |
| xfer_irq | output | NCH | Per-channel transfer interrupt |
| ack_irq | output | NCH | Per-channel acknowledge interrupt |
| comb_irq | output | 1 | Combined interrupt |

## Verification
A corrupted pending, mask or acknowledge word reaches the read ports of whichever channel is selected in the very next cycle. The per-channel interrupt levels expose it at the same time whenever the bad bit is unmasked. The bench compares every interrupt and both read ports against its model after every clock, and it rotates the read selectors, so a wrong bit on any channel appears within a few cycles. Lost-event faults show up in the same-cycle set and clear cases, and wrong acknowledge sources show up as acknowledge flags that do not match the pending-before-clear value.

// File: rtl/dbmb_pkg.sv
package dbmb_pkg;
  typedef enum logic { SND_OP_SET = 1'b0, SND_OP_ACKCLR = 1'b1 } snd_op_e;
  typedef enum logic { RCV_OP_CLR = 1'b0, RCV_OP_MASK = 1'b1 } rcv_op_e;
endpackage

// File: rtl/dbmb_dec.sv
module dbmb_dec #(
  parameter int NCH = 5,
  parameter int CW  = 3
) (
  input  logic           en,
  input  logic [CW-1:0]  ch,
  output logic [NCH-1:0] hit
);
  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign hit[i] = en && (ch == CW'(i));
  end
endmodule

// File: rtl/dbmb_rdmux.sv
module dbmb_rdmux #(
  parameter int NCH = 5,
  parameter int FW  = 32,
  parameter int CW  = 3
) (
  input  logic [CW-1:0]          sel,
  input  logic [NCH-1:0][FW-1:0] words,
  output logic [FW-1:0]          dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel == CW'(i)) dout = words[i];
    end
  end
endmodule

// File: rtl/dbmb_chan.sv
module dbmb_chan #(
  parameter int FW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_we,
  input  logic          ackclr_we,
  input  logic [FW-1:0] snd_bits,
  input  logic          clr_we,
  input  logic          msk_we,
  input  logic          ack_req,
  input  logic [FW-1:0] rcv_bits,
  output logic [FW-1:0] pend_q,
  output logic [FW-1:0] mask_q,
  output logic [FW-1:0] ack_q,
  output logic          xfer_irq,
  output logic          ack_irq
);
  logic [FW-1:0] pend_d, mask_d, ack_d;
  logic [FW-1:0] set_v, clr_v, ackclr_v, ackset_v;
  logic          upd_en;

  always_comb begin
    set_v    = set_we    ? snd_bits : '0;
    ackclr_v = ackclr_we ? snd_bits : '0;
    clr_v    = clr_we    ? rcv_bits : '0;
    ackset_v = (clr_we && ack_req) ? (rcv_bits & pend_q) : '0;
    // set applied after clear: a simultaneous set survives
    pend_d   = (pend_q & ~clr_v) | set_v;
    mask_d   = msk_we ? rcv_bits : mask_q;
    // new acknowledge applied after sender clear
    ack_d    = (ack_q & ~ackclr_v) | ackset_v;
    upd_en   = set_we | ackclr_we | clr_we | msk_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '0;
      ack_q  <= '0;
    end else if (upd_en) begin
      pend_q <= pend_d;
      mask_q <= mask_d;
      ack_q  <= ack_d;
    end
  end

  assign xfer_irq = |(pend_q & ~mask_q);
  assign ack_irq  = |ack_q;
endmodule

// File: rtl/dbmb_top.sv
module dbmb_top
  import dbmb_pkg::*;
#(
  parameter int NCH = 5,
  parameter int FW  = 32,
  parameter int CW  = (NCH > 1) ? $clog2(NCH + 1) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           snd_wr_en,
  input  logic           snd_wr_op,
  input  logic [CW-1:0]  snd_ch,
  input  logic [FW-1:0]  snd_data,
  input  logic [CW-1:0]  snd_rd_ch,
  output logic [FW-1:0]  snd_rd_pend,
  output logic [FW-1:0]  snd_rd_ack,
  input  logic           rcv_wr_en,
  input  logic           rcv_wr_op,
  input  logic           rcv_ack_req,
  input  logic [CW-1:0]  rcv_ch,
  input  logic [FW-1:0]  rcv_data,
  input  logic [CW-1:0]  rcv_rd_ch,
  output logic [FW-1:0]  rcv_rd_pend,
  output logic [FW-1:0]  rcv_rd_mask,
  output logic [NCH-1:0] xfer_irq,
  output logic [NCH-1:0] ack_irq,
  output logic           comb_irq
);
  logic [NCH-1:0]         snd_hit, rcv_hit;
  logic [NCH-1:0][FW-1:0] pend_all, mask_all, ack_all;
  logic                   snd_set_op, snd_ackclr_op, rcv_clr_op, rcv_msk_op;

  assign snd_set_op    = (snd_op_e'(snd_wr_op) == SND_OP_SET);
  assign snd_ackclr_op = (snd_op_e'(snd_wr_op) == SND_OP_ACKCLR);
  assign rcv_clr_op    = (rcv_op_e'(rcv_wr_op) == RCV_OP_CLR);
  assign rcv_msk_op    = (rcv_op_e'(rcv_wr_op) == RCV_OP_MASK);

  dbmb_dec #(.NCH(NCH), .CW(CW)) u_snd_dec (.en(snd_wr_en), .ch(snd_ch), .hit(snd_hit));
  dbmb_dec #(.NCH(NCH), .CW(CW)) u_rcv_dec (.en(rcv_wr_en), .ch(rcv_ch), .hit(rcv_hit));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dbmb_chan #(.FW(FW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_we    (snd_hit[c] && snd_set_op),
      .ackclr_we (snd_hit[c] && snd_ackclr_op),
      .snd_bits  (snd_data),
      .clr_we    (rcv_hit[c] && rcv_clr_op),
      .msk_we    (rcv_hit[c] && rcv_msk_op),
      .ack_req   (rcv_ack_req),
      .rcv_bits  (rcv_data),
      .pend_q    (pend_all[c]),
      .mask_q    (mask_all[c]),
      .ack_q     (ack_all[c]),
      .xfer_irq  (xfer_irq[c]),
      .ack_irq   (ack_irq[c])
    );
  end

  dbmb_rdmux #(.NCH(NCH), .FW(FW), .CW(CW)) u_mux_sp (.sel(snd_rd_ch), .words(pend_all), .dout(snd_rd_pend));
  dbmb_rdmux #(.NCH(NCH), .FW(FW), .CW(CW)) u_mux_sa (.sel(snd_rd_ch), .words(ack_all),  .dout(snd_rd_ack));
  dbmb_rdmux #(.NCH(NCH), .FW(FW), .CW(CW)) u_mux_rp (.sel(rcv_rd_ch), .words(pend_all), .dout(rcv_rd_pend));
  dbmb_rdmux #(.NCH(NCH), .FW(FW), .CW(CW)) u_mux_rm (.sel(rcv_rd_ch), .words(mask_all), .dout(rcv_rd_mask));

  assign comb_irq = (|xfer_irq) | (|ack_irq);
endmodule

// File: rtl/dbmb_chk.sv
module dbmb_chk #(
  parameter int NCH = 5,
  parameter int FW  = 32,
  parameter int CW  = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   snd_wr_en,
  input logic                   snd_wr_op,
  input logic [CW-1:0]          snd_ch,
  input logic [FW-1:0]          snd_data,
  input logic                   rcv_wr_en,
  input logic                   rcv_wr_op,
  input logic                   rcv_ack_req,
  input logic [CW-1:0]          rcv_ch,
  input logic [FW-1:0]          rcv_data,
  input logic [NCH-1:0][FW-1:0] pend_all,
  input logic [NCH-1:0][FW-1:0] mask_all,
  input logic [NCH-1:0][FW-1:0] ack_all,
  input logic [NCH-1:0]         xfer_irq,
  input logic [NCH-1:0]         ack_irq,
  input logic                   comb_irq
);
  for (genvar c = 0; c < NCH; c++) begin : g_c
    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (snd_wr_en && !snd_wr_op && snd_ch == CW'(c))
      |=> ((pend_all[c] & $past(snd_data)) == $past(snd_data)));

    a_r3_clear_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (rcv_wr_en && !rcv_wr_op && rcv_ch == CW'(c) && !(snd_wr_en && !snd_wr_op && snd_ch == CW'(c)))
      |=> ((pend_all[c] & $past(rcv_data)) == '0));

    a_r10_untouched_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!(snd_wr_en && snd_ch == CW'(c)) && !(rcv_wr_en && rcv_ch == CW'(c)))
      |=> ($stable(pend_all[c]) && $stable(mask_all[c]) && $stable(ack_all[c])));

    a_r8_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_irq[c] && !(snd_wr_en && snd_wr_op && snd_ch == CW'(c))) |=> ack_irq[c]);

    a_r6_no_ack_unrequested: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_irq[c] && !(rcv_wr_en && !rcv_wr_op && rcv_ack_req && rcv_ch == CW'(c)))
      |=> !ack_irq[c]);
  end

  a_r9_comb_covers: assert property (@(posedge clk) disable iff (!rst_n)
    ((xfer_irq != '0) || (ack_irq != '0)) |-> comb_irq);
endmodule

bind dbmb_top dbmb_chk #(.NCH(NCH), .FW(FW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .snd_wr_en(snd_wr_en), .snd_wr_op(snd_wr_op), .snd_ch(snd_ch), .snd_data(snd_data),
  .rcv_wr_en(rcv_wr_en), .rcv_wr_op(rcv_wr_op), .rcv_ack_req(rcv_ack_req),
  .rcv_ch(rcv_ch), .rcv_data(rcv_data),
  .pend_all(pend_all), .mask_all(mask_all), .ack_all(ack_all),
  .xfer_irq(xfer_irq), .ack_irq(ack_irq), .comb_irq(comb_irq)
);

// File: tb/dbmb_top_tb.sv
module dbmb_top_tb;
  localparam int NCH = 5;
  localparam int FW  = 32;
  localparam int CW  = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic snd_wr_en, snd_wr_op, rcv_wr_en, rcv_wr_op, rcv_ack_req;
  logic [CW-1:0] snd_ch, snd_rd_ch, rcv_ch, rcv_rd_ch;
  logic [FW-1:0] snd_data, rcv_data;
  logic [FW-1:0] snd_rd_pend, snd_rd_ack, rcv_rd_pend, rcv_rd_mask;
  logic [NCH-1:0] xfer_irq, ack_irq;
  logic comb_irq;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";
  bit done = 0;

  logic [FW-1:0] m_pend [NCH];
  logic [FW-1:0] m_mask [NCH];
  logic [FW-1:0] m_ack  [NCH];

  always #5ns clk = ~clk;

  dbmb_top #(.NCH(NCH), .FW(FW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .snd_wr_en(snd_wr_en), .snd_wr_op(snd_wr_op), .snd_ch(snd_ch), .snd_data(snd_data),
    .snd_rd_ch(snd_rd_ch), .snd_rd_pend(snd_rd_pend), .snd_rd_ack(snd_rd_ack),
    .rcv_wr_en(rcv_wr_en), .rcv_wr_op(rcv_wr_op), .rcv_ack_req(rcv_ack_req),
    .rcv_ch(rcv_ch), .rcv_data(rcv_data), .rcv_rd_ch(rcv_rd_ch),
    .rcv_rd_pend(rcv_rd_pend), .rcv_rd_mask(rcv_rd_mask),
    .xfer_irq(xfer_irq), .ack_irq(ack_irq), .comb_irq(comb_irq)
  );

  task automatic chk(string what, logic [FW-1:0] act, logic [FW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] rd(logic [FW-1:0] arr [NCH], logic [CW-1:0] ch);
    return (int'(ch) < NCH) ? arr[ch] : '0;
  endfunction

  task automatic compare_all();
    logic [NCH-1:0] ex, ea;
    for (int c = 0; c < NCH; c++) begin
      ex[c] = |(m_pend[c] & ~m_mask[c]);
      ea[c] = |m_ack[c];
    end
    chk("xfer_irq", FW'(xfer_irq), FW'(ex));
    chk("ack_irq",  FW'(ack_irq),  FW'(ea));
    chk("comb_irq", FW'(comb_irq), FW'((|ex) | (|ea)));
    chk("snd_rd_pend", snd_rd_pend, rd(m_pend, snd_rd_ch));
    chk("snd_rd_ack",  snd_rd_ack,  rd(m_ack,  snd_rd_ch));
    chk("rcv_rd_pend", rcv_rd_pend, rd(m_pend, rcv_rd_ch));
    chk("rcv_rd_mask", rcv_rd_mask, rd(m_mask, rcv_rd_ch));
  endtask

  task automatic model_step();
    for (int c = 0; c < NCH; c++) begin
      logic [FW-1:0] setv, clrv, ackc, acks;
      setv = (snd_wr_en && !snd_wr_op && int'(snd_ch) == c) ? snd_data : '0;
      ackc = (snd_wr_en &&  snd_wr_op && int'(snd_ch) == c) ? snd_data : '0;
      clrv = (rcv_wr_en && !rcv_wr_op && int'(rcv_ch) == c) ? rcv_data : '0;
      acks = (rcv_ack_req) ? (clrv & m_pend[c]) : '0;
      if (rcv_wr_en && rcv_wr_op && int'(rcv_ch) == c) m_mask[c] = rcv_data;
      m_ack[c]  = (m_ack[c] & ~ackc) | acks;
      m_pend[c] = (m_pend[c] & ~clrv) | setv;
    end
  endtask

  int rot = 0;
  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    snd_wr_en = 0; rcv_wr_en = 0; rcv_ack_req = 0;
    snd_rd_ch = CW'(rot % 8);
    rcv_rd_ch = CW'((rot + 3) % 8);
    rot++;
    #1;
    compare_all();
  endtask

  task automatic snd(logic op, int ch, logic [FW-1:0] d);
    snd_wr_en = 1; snd_wr_op = op; snd_ch = CW'(ch); snd_data = d;
  endtask

  task automatic rcv(logic op, logic req, int ch, logic [FW-1:0] d);
    rcv_wr_en = 1; rcv_wr_op = op; rcv_ack_req = req; rcv_ch = CW'(ch); rcv_data = d;
  endtask

  initial begin
    #2ms;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0;
    snd_wr_en = 0; snd_wr_op = 0; snd_ch = '0; snd_data = '0; snd_rd_ch = '0;
    rcv_wr_en = 0; rcv_wr_op = 0; rcv_ack_req = 0; rcv_ch = '0; rcv_data = '0; rcv_rd_ch = '0;
    for (int c = 0; c < NCH; c++) begin m_pend[c] = '0; m_mask[c] = '0; m_ack[c] = '0; end
    repeat (3) @(negedge clk);
    tag = "R1"; #1; compare_all();
    rst_n = 1;
    cyc();
    // R2: set on one channel, zero bits untouched
    tag = "R2";
    snd(0, 1, 32'h0000_00A5); cyc();
    snd(0, 1, 32'h8000_0000); cyc();
    snd(0, 3, 32'h0F0F_0000); cyc();
    for (int i = 0; i < 8; i++) cyc();
    // R3: clear part of the pending flags
    tag = "R3";
    rcv(0, 0, 1, 32'h0000_0005); cyc();
    rcv(0, 0, 3, 32'h0000_FFFF); cyc();
    // R4: set and clear same flag same cycle
    tag = "R4";
    snd(0, 2, 32'h0000_0011); rcv(0, 0, 2, 32'h0000_0011); cyc();
    snd(0, 2, 32'h0000_0100); rcv(0, 0, 2, 32'h0000_0111); cyc();
    // R5: mask hides and reveals
    tag = "R5";
    rcv(1, 0, 2, 32'hFFFF_FFFF); cyc();
    rcv(1, 0, 1, 32'h0000_00A0); cyc();
    rcv(1, 0, 1, 32'h0000_0080); cyc();
    rcv(1, 0, 2, 32'h0000_0000); cyc();
    for (int i = 0; i < 8; i++) cyc();
    // R6: acknowledge on clear with and without request
    tag = "R6";
    rcv(0, 1, 1, 32'hFFFF_FFFF); cyc();
    rcv(0, 0, 3, 32'h0F00_0000); cyc();
    rcv(0, 1, 4, 32'h0000_0001); cyc();
    for (int i = 0; i < 8; i++) cyc();
    // R7/R8: sender clears acknowledge, new ack wins
    tag = "R7";
    snd(1, 1, 32'h0000_0020); cyc();
    snd(0, 0, 32'h0000_0003); cyc();
    snd(1, 0, 32'h0000_0001); rcv(0, 1, 0, 32'h0000_0003); cyc();
    tag = "R8";
    snd(1, 1, 32'hFFFF_FFFF); cyc();
    snd(1, 0, 32'hFFFF_FFFF); cyc();
    // R10: out-of-range channel writes ignored, reads zero
    tag = "R10";
    snd(0, 6, 32'hFFFF_FFFF); cyc();
    rcv(1, 0, 7, 32'hFFFF_FFFF); cyc();
    rcv(0, 1, 5, 32'hFFFF_FFFF); cyc();
    for (int i = 0; i < 8; i++) cyc();
    // R9: mixed traffic, combined interrupt tracked throughout
    tag = "R9";
    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 1) == 1)
        snd($urandom_range(0, 1), $urandom_range(0, 7), $urandom & $urandom);
      if ($urandom_range(0, 1) == 1)
        rcv($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 7), $urandom | $urandom);
      cyc();
    end
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule